// File: doc/BRIEF.md
# Byte FIFO with Occupancy Count and Programmable Threshold Interrupt

This block is a 64-byte first-in first-out buffer for one direction of a serial port. Alongside the data path it exposes an exact occupancy count from 0 to 64 and holds an 8-bit threshold that software writes. A comparator turns the count and the threshold into an interrupt. The build-time parameter `DIR` selects the comparison sense. In transmit use (`DIR_TX`) the interrupt requests more data while the buffer holds fewer bytes than the threshold. In receive use (`DIR_RX`) it requests draining once the buffer holds at least the threshold.

The count can change between two bus reads, so software should accept a value only after reading the same number twice. The block keeps the count exact on every accepted push and pop. Occupancy is tracked by a three-state machine:
- `OCC_EMPTY` goes to `OCC_PARTIAL` on an accepted push.
- `OCC_PARTIAL` goes to `OCC_FULL` on a lone push at a count of 63.
- `OCC_PARTIAL` goes back to `OCC_EMPTY` on a lone pop at a count of 1.
- `OCC_FULL` goes to `OCC_PARTIAL` on any accepted pop.

The read side is show-ahead: `pop_data` always presents the oldest stored byte.

Top module: `fifo_lvl_trig`

## Requirements
- R1: While `rst_n` is low and after its release, `level` is 0, the buffer is empty and the threshold is 0.
- R2: A push with no pop while `level` is below 64 stores `push_data`, and `level` is one higher after that clock edge; `level` never exceeds 64.
- R3: A pop with no push while `level` is above 0 removes the oldest byte, and `level` is one lower after that clock edge; `pop_data` always shows the oldest stored byte, in write order.
- R4: A push and a pop in the same cycle with `level` between 1 and 63 leave `level` unchanged and keep byte order.
- R5: A push while `level` is 64 is ignored, even if a pop comes in the same cycle (the pop is still taken, giving 63).
- R6: A pop while `level` is 0 is ignored, even if a push comes in the same cycle (the push is still taken, giving 1).
- R7: A threshold write (`trig_wr` high) takes effect from the next cycle; written values above 64 are stored as 64.
- R8: With `DIR_TX`, `irq` is high exactly when `level` is less than the threshold.
- R9: With `DIR_RX`, `irq` is high exactly when `level` is greater than or equal to the threshold.
- R10: `irq` is combinational from the registered count and threshold, so it changes in the same cycle that either register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write request |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Read request |
| pop_data | output | 8 | Oldest stored byte (show-ahead) |
| level | output | 8 | Occupancy count, 0 to 64 |
| trig_wr | input | 1 | Threshold write strobe |
| trig_data | input | 8 | Threshold value to write |
| irq | output | 1 | Threshold interrupt |

## Verification
The following results become visible one edge after the inputs that cause them are sampled:
- `level` after a push or pop;
- the new head byte on `pop_data`;
- the effect of a threshold write.

`irq` follows in that same cycle, with no extra register. The bench drives inputs at the falling edge and advances its queue model at the rising edge. It compares every output at the next falling edge, so each comparison falls exactly one edge after its stimulus. Two instances, one per direction, share the stimulus, so both comparison senses are checked against the same sequence of counts.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;
endpackage

// File: rtl/lvl_fsm.sv
module lvl_fsm
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output occ_state_e    state
);
    localparam logic [CW-1:0] TOP_M1 = CW'(DEPTH - 1);

    occ_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY:   if (push_ok) state_d = OCC_PARTIAL;
            OCC_PARTIAL: begin
                if (push_ok && !pop_ok && count_q == TOP_M1)
                    state_d = OCC_FULL;
                else if (pop_ok && !push_ok && count_q == CW'(1))
                    state_d = OCC_EMPTY;
            end
            OCC_FULL:    if (pop_ok) state_d = OCC_PARTIAL;
            default:     state_d = OCC_EMPTY;
        endcase
    end

    // outputs and count update
    always_comb begin
        push_ok = push && (state_q != OCC_FULL);
        pop_ok  = pop  && (state_q != OCC_EMPTY);
        count_d = count_q;
        unique case ({push_ok, pop_ok})
            2'b10:   count_d = count_q + CW'(1);
            2'b01:   count_d = count_q - CW'(1);
            default: count_d = count_q;
        endcase
    end

    assign count = count_q;
    assign state = state_q;
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         re,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (we) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (re) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import fifo_lvl_pkg::*;
#(
    parameter int   DEPTH = 64,
    parameter int   CW    = 8,
    parameter dir_e DIR   = DIR_RX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_wr,
    input  logic [CW-1:0] trig_data,
    input  logic [CW-1:0] count,
    output logic          irq
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [CW-1:0] thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       thr_q <= '0;
        else if (trig_wr) thr_q <= (trig_data > CAP) ? CAP : trig_data;
    end

    generate
        if (DIR == DIR_TX) begin : g_tx
            assign irq = (count < thr_q);
        end else begin : g_rx
            assign irq = (count >= thr_q);
        end
    endgenerate
endmodule

// File: rtl/fifo_lvl_trig.sv
module fifo_lvl_trig
    import fifo_lvl_pkg::*;
#(
    parameter int   DEPTH = 64,
    parameter int   W     = 8,
    parameter int   CW    = 8,
    parameter dir_e DIR   = DIR_RX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] level,
    input  logic          trig_wr,
    input  logic [CW-1:0] trig_data,
    output logic          irq
);
    logic       push_ok, pop_ok;
    occ_state_e occ;

    lvl_fsm #(.DEPTH(DEPTH), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_ok(push_ok), .pop_ok(pop_ok), .count(level), .state(occ)
    );

    byte_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(push_ok), .wdata(push_data),
        .re(pop_ok), .rdata(pop_data)
    );

    trig_cmp #(.DEPTH(DEPTH), .CW(CW), .DIR(DIR)) u_cmp (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_data(trig_data),
        .count(level), .irq(irq)
    );
endmodule

// File: rtl/fifo_lvl_chk.sv
module fifo_lvl_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] level
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP); // R2
    AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level < TOP) |=> level == $past(level) + CW'(1)); // R2
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level != '0) |=> level == $past(level) - CW'(1)); // R3
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0 && level < TOP) |=> $stable(level)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == TOP) |=> level == TOP); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> level == '0); // R6
endmodule

bind fifo_lvl_trig fifo_lvl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .level(level)
);

// File: tb/tb_fifo_lvl_trig.sv
module tb_fifo_lvl_trig;
    import fifo_lvl_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       push, pop, trig_wr;
    logic [7:0] push_data, trig_data;
    logic [7:0] pop_data, level, pop_data_tx, level_tx;
    logic       irq, irq_tx;

    int   checks = 0;
    int   errors = 0;
    byte unsigned q[$];
    int   thr_m = 0;

    always #4 clk = ~clk;

    fifo_lvl_trig #(.DIR(DIR_RX)) dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .level(level),
        .trig_wr(trig_wr), .trig_data(trig_data), .irq(irq)
    );

    fifo_lvl_trig #(.DIR(DIR_TX)) dut_tx (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data_tx), .level(level_tx),
        .trig_wr(trig_wr), .trig_data(trig_data), .irq(irq_tx)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " level"}, int'(level), q.size());
        chk({tag, " level tx"}, int'(level_tx), q.size());
        if (q.size() > 0) begin
            chk({tag, " R3 head"}, int'(pop_data), int'(q[0]));
            chk({tag, " R3 head tx"}, int'(pop_data_tx), int'(q[0]));
        end
        chk({tag, " R9 R10 irq rx"}, int'(irq), int'(q.size() >= thr_m));
        chk({tag, " R8 R10 irq tx"}, int'(irq_tx), int'(q.size() < thr_m));
    endtask

    // drive one cycle, advance model at rising edge, compare at next falling edge
    task automatic cyc(bit ps, byte unsigned d, bit pp, bit tw, byte unsigned td, string tag);
        bit full, empty;
        push = ps; push_data = d; pop = pp; trig_wr = tw; trig_data = td;
        @(posedge clk);
        full  = (q.size() == 64);
        empty = (q.size() == 0);
        if (pp && !empty) void'(q.pop_front());
        if (ps && !full) q.push_back(d);
        if (tw) thr_m = (td > 64) ? 64 : int'(td);
        @(negedge clk);
        push = 0; pop = 0; trig_wr = 0;
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; push = 0; pop = 0; trig_wr = 0; push_data = 0; trig_data = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after release");

        cyc(0, 0, 0, 1, 10, "R7 thr 10");
        for (int i = 0; i < 64; i++) cyc(1, byte'(i * 3 + 1), 0, 0, 0, "R2 fill");
        cyc(1, 8'hEE, 0, 0, 0, "R5 push at full");
        cyc(1, 8'hEF, 0, 0, 0, "R5 push at full again");
        cyc(1, 8'hF0, 1, 0, 0, "R5 push+pop at full");
        cyc(1, 8'hF1, 0, 0, 0, "R2 refill");
        cyc(0, 0, 0, 1, 200, "R7 saturate 200");
        cyc(0, 0, 0, 1, 64, "R7 write 64");
        for (int i = 0; i < 64; i++) cyc(0, 0, 1, 0, 0, "R3 drain");
        cyc(0, 0, 1, 0, 0, "R6 pop at empty");
        cyc(1, 8'h5A, 1, 0, 0, "R6 push+pop at empty");
        cyc(0, 0, 0, 1, 3, "R7 thr 3");
        for (int i = 0; i < 4; i++) cyc(1, byte'(8'h80 + i), 0, 0, 0, "R2 push");
        for (int i = 0; i < 20; i++) cyc(1, byte'(8'h10 + i), 1, 0, 0, "R4 push+pop");
        cyc(0, 0, 0, 1, 0, "R7 thr 0");
        for (int i = 0; i < 3000; i++) begin
            bit tw = ($urandom_range(0, 15) == 0);
            cyc(bit'($urandom_range(0, 1)), byte'($urandom_range(0, 255)),
                bit'($urandom_range(0, 2) == 0), tw, byte'($urandom_range(0, 90)),
                "R2 R3 R4 R5 R6 R7 mix");
        end
        for (int i = 0; i < 70; i++) cyc(1, byte'(i), 0, 0, 0, "R5 fill mix");
        for (int i = 0; i < 70; i++) cyc(0, 0, 1, 0, 0, "R6 drain mix");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule